// File: doc/BRIEF.md
# Clock Sync State Controller

This block supervises a disciplined-clock loop. It does none of the filtering or loop arithmetic. It follows the loop through five phases: acquiring lock, arming the next one-second compare value, tracking while locked, holding over while timing messages are missing, and re-calibrating after a large drift. It reports the phase to the loop logic. It also tells the loop whether to freeze its DAC control word or keep steering it, and it raises a one-cycle request whenever a fresh compare value must be loaded.

Single-cycle status strobes from the loop software or hardware drive the transitions. A strobe can mark time sync achieved, output pulse produced, sync messages lost, sync messages back, drift within limits, drift far off, or absolute reference lost. The locked phase lasts a fixed number of clock cycles before the controller returns to compare-load. A timer inside the block measures this period, so the compare reload repeats without any extra input. When sync messages come back during holdover, the drift verdict given with them selects one of three exits.

Top module: `clkSyncSupervisor`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `state` is 0 (initial lock), `loopEn` is 1, `holdDac` is 0 and `cmpLoad` is 0.
- R2: The state codes are 0 initial lock, 1 sync output, 2 in-lock, 3 holdover and 4 re-sync. In initial lock, `syncAchieved` moves `state` to 1 on the next clock. Otherwise the state stays 0.
- R3: In sync output, `pulseDone` moves `state` to 2 on the next clock.
- R4: Each visit to in-lock lasts exactly `PERIOD_CYCLES` cycles and then returns to sync output, unless sync is lost first.
- R5: `syncLost` takes priority over every other strobe. In sync output, in-lock and re-sync it moves `state` to 3 on the next clock. In initial lock and holdover it blocks any transition in that cycle.
- R6: In holdover, `syncBack` selects the exit in this order: with `refLost` to 0, otherwise with `driftFar` to 4, otherwise with `driftOk` to 2. With none of the three, the state stays in holdover.
- R7: In re-sync, `syncAchieved` moves `state` to 1 on the next clock.
- R8: `holdDac` is 1 exactly in the cycles where `state` is 3. `loopEn` is 1 exactly in the cycles where it is not.
- R9: `cmpLoad` is 1 for exactly one cycle, the first cycle of each visit to sync output, and is 0 at all other times.
- R10: A strobe that the current state does not list has no effect on `state` or the other outputs, for example `pulseDone` outside sync output or `syncBack` outside holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncAchieved | input | 1 | Loop reports time sync achieved |
| pulseDone | input | 1 | Output pulse was produced |
| syncLost | input | 1 | Sync messages stopped arriving |
| syncBack | input | 1 | Sync messages arriving again |
| driftOk | input | 1 | Measured drift within limits |
| driftFar | input | 1 | Measured drift too large |
| refLost | input | 1 | Absolute time reference lost |
| state | output | 3 | Current phase code (see R2) |
| holdDac | output | 1 | Freeze the DAC control value |
| loopEn | output | 1 | Loop filter allowed to steer |
| cmpLoad | output | 1 | One-cycle request to load next compare value |

## Verification
A strobe sampled at a clock edge shows up in `state`, `holdDac`, `loopEn` and `cmpLoad` right after that same edge. All four are registered together, so the latency is one cycle from the strobe, with no extra stage. The in-lock return to sync output comes `PERIOD_CYCLES` edges after the edge that entered in-lock. The bench drives strobes on the falling edge and advances its behavioural model at the rising edge. It compares all four outputs against the model on the following falling edge, so each result is checked in the cycle it is due.

// File: rtl/clk_sync_pkg.sv
package clk_sync_pkg;

  typedef enum logic [2:0] {
    ST_INIT     = 3'd0,
    ST_SYNC_OUT = 3'd1,
    ST_IN_LOCK  = 3'd2,
    ST_HOLD     = 3'd3,
    ST_RESYNC   = 3'd4
  } syncState_t;

  // Strobes from control to datapath, describing the state being entered
  typedef struct packed {
    logic loadNext;   // next state is sync output, current is not
    logic holdNext;   // next state is holdover
    logic lockNext;   // next state is in-lock
    logic lockEntry;  // in-lock is being entered from another state
  } ctrlStrobe_t;

endpackage

// File: rtl/clk_sync_ctrl.sv
module clk_sync_ctrl
  import clk_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncAchieved,
  input  logic        pulseDone,
  input  logic        syncLost,
  input  logic        syncBack,
  input  logic        driftOk,
  input  logic        driftFar,
  input  logic        refLost,
  input  logic        periodDone,
  output syncState_t  curState,
  output ctrlStrobe_t strobe
);

  syncState_t nxtState;

  always_comb begin
    nxtState = curState;
    case (curState)
      ST_INIT: begin
        if (!syncLost && syncAchieved) nxtState = ST_SYNC_OUT;
      end
      ST_SYNC_OUT: begin
        if (syncLost)       nxtState = ST_HOLD;
        else if (pulseDone) nxtState = ST_IN_LOCK;
      end
      ST_IN_LOCK: begin
        if (syncLost)        nxtState = ST_HOLD;
        else if (periodDone) nxtState = ST_SYNC_OUT;
      end
      ST_HOLD: begin
        if (!syncLost && syncBack) begin
          if (refLost)       nxtState = ST_INIT;
          else if (driftFar) nxtState = ST_RESYNC;
          else if (driftOk)  nxtState = ST_IN_LOCK;
        end
      end
      ST_RESYNC: begin
        if (syncLost)          nxtState = ST_HOLD;
        else if (syncAchieved) nxtState = ST_SYNC_OUT;
      end
      default: nxtState = ST_INIT;
    endcase
  end

  always_comb begin
    strobe.loadNext  = (nxtState == ST_SYNC_OUT) && (curState != ST_SYNC_OUT);
    strobe.holdNext  = (nxtState == ST_HOLD);
    strobe.lockNext  = (nxtState == ST_IN_LOCK);
    strobe.lockEntry = (nxtState == ST_IN_LOCK) && (curState != ST_IN_LOCK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= ST_INIT;
    else       curState <= nxtState;
  end

  // R5
  lost_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncLost && (curState inside {ST_SYNC_OUT, ST_IN_LOCK, ST_RESYNC}))
      |=> (curState == ST_HOLD));

  // R2
  init_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_INIT) |=> (curState inside {ST_INIT, ST_SYNC_OUT}));

  // R6
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((curState == ST_HOLD) && (!syncBack || syncLost)) |=> (curState == ST_HOLD));

  // R7
  resync_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((curState == ST_RESYNC) && !syncLost && syncAchieved) |=> (curState == ST_SYNC_OUT));

endmodule

// File: rtl/clk_sync_dp.sv
module clk_sync_dp
  import clk_sync_pkg::*;
#(
  parameter int PERIOD_CYCLES = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output logic        periodDone,
  output logic        holdDac,
  output logic        loopEn,
  output logic        cmpLoad
);

  localparam int CNT_W = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYCLES - 1);

  logic [CNT_W-1:0] lockCnt;

  assign periodDone = (lockCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockCnt <= '0;
    end else if (strobe.lockEntry) begin
      lockCnt <= '0;
    end else if (strobe.lockNext) begin
      lockCnt <= lockCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdDac <= 1'b0;
      loopEn  <= 1'b1;
      cmpLoad <= 1'b0;
    end else begin
      holdDac <= strobe.holdNext;
      loopEn  <= !strobe.holdNext;
      cmpLoad <= strobe.loadNext;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockCnt <= LAST);

  // R9
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpLoad |=> !cmpLoad);

endmodule

// File: rtl/clkSyncSupervisor.sv
module clkSyncSupervisor
  import clk_sync_pkg::*;
#(
  parameter int PERIOD_CYCLES = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncAchieved,
  input  logic       pulseDone,
  input  logic       syncLost,
  input  logic       syncBack,
  input  logic       driftOk,
  input  logic       driftFar,
  input  logic       refLost,
  output logic [2:0] state,
  output logic       holdDac,
  output logic       loopEn,
  output logic       cmpLoad
);

  syncState_t  curState;
  ctrlStrobe_t strobe;
  logic        periodDone;

  clk_sync_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .syncAchieved (syncAchieved),
    .pulseDone    (pulseDone),
    .syncLost     (syncLost),
    .syncBack     (syncBack),
    .driftOk      (driftOk),
    .driftFar     (driftFar),
    .refLost      (refLost),
    .periodDone   (periodDone),
    .curState     (curState),
    .strobe       (strobe)
  );

  clk_sync_dp #(.PERIOD_CYCLES(PERIOD_CYCLES)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .periodDone (periodDone),
    .holdDac    (holdDac),
    .loopEn     (loopEn),
    .cmpLoad    (cmpLoad)
  );

  assign state = curState;

  // R8
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdDac == (curState == ST_HOLD));

  // R8
  loop_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopEn == (curState != ST_HOLD));

  // R9
  load_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpLoad |-> ((curState == ST_SYNC_OUT) && ($past(curState) != ST_SYNC_OUT)));

endmodule

// File: tb/test_clkSyncSupervisor.sv
module test_clkSyncSupervisor;

  localparam int PERIOD = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sAch = 0, sPulse = 0, sLost = 0, sBack = 0, sOk = 0, sFar = 0, sRef = 0;
  logic [2:0] state;
  logic holdDac, loopEn, cmpLoad;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model
  int mState = 0;
  int mLockCycles = 0;
  bit mLoad = 0;

  always #10 clk = ~clk;

  clkSyncSupervisor #(.PERIOD_CYCLES(PERIOD)) i_clkSyncSupervisor (
    .clk(clk), .rstN(rstN),
    .syncAchieved(sAch), .pulseDone(sPulse), .syncLost(sLost), .syncBack(sBack),
    .driftOk(sOk), .driftFar(sFar), .refLost(sRef),
    .state(state), .holdDac(holdDac), .loopEn(loopEn), .cmpLoad(cmpLoad)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic modelStep();
    int prev;
    int nxt;
    prev = mState;
    nxt = prev;
    case (prev)
      0: if (!sLost && sAch) nxt = 1;
      1: if (sLost) nxt = 3; else if (sPulse) nxt = 2;
      2: if (sLost) nxt = 3; else if (mLockCycles == PERIOD) nxt = 1;
      3: if (!sLost && sBack) begin
           if (sRef) nxt = 0;
           else if (sFar) nxt = 4;
           else if (sOk) nxt = 2;
         end
      4: if (sLost) nxt = 3; else if (sAch) nxt = 1;
      default: nxt = 0;
    endcase
    if (nxt == 2) mLockCycles = (prev == 2) ? mLockCycles + 1 : 1;
    else mLockCycles = 0;
    mLoad = (nxt == 1) && (prev != 1);
    mState = nxt;
  endtask

  // one clock with given strobes; compare on the following falling edge
  task automatic step(string req, bit a, bit p, bit l, bit b, bit o, bit f, bit r);
    sAch = a; sPulse = p; sLost = l; sBack = b; sOk = o; sFar = f; sRef = r;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    sAch = 0; sPulse = 0; sLost = 0; sBack = 0; sOk = 0; sFar = 0; sRef = 0;
    check(req, int'(state), mState);
    check("R8 holdDac", int'(holdDac), (mState == 3) ? 1 : 0);
    check("R8 loopEn", int'(loopEn), (mState == 3) ? 0 : 1);
    check("R9 cmpLoad", int'(cmpLoad), int'(mLoad));
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) step(req, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 state", int'(state), 0);
    check("R1 loopEn", int'(loopEn), 1);
    check("R1 holdDac", int'(holdDac), 0);
    check("R1 cmpLoad", int'(cmpLoad), 0);
    rstN = 1'b1;
    idle("R1 after release", 1);
    // R10: strobes not listed for initial lock
    step("R10 pulse in init", 0, 1, 0, 0, 0, 0, 0);
    step("R10 back in init", 0, 0, 0, 1, 1, 1, 1);
    // R5: loss blocks advance in initial lock
    step("R5 lost+ach in init", 1, 0, 1, 0, 0, 0, 0);
    // R2
    step("R2 init to sync out", 1, 0, 0, 0, 0, 0, 0);
    step("R10 ach in sync out", 1, 0, 0, 1, 0, 0, 0);
    idle("R9 stay sync out", 2);
    // R3
    step("R3 pulse to in-lock", 0, 1, 0, 0, 0, 0, 0);
    // R4: two full reload rounds
    idle("R4 in-lock period", PERIOD + 1);
    step("R3 pulse again", 0, 1, 0, 0, 0, 0, 0);
    idle("R4 second period", PERIOD + 2);
    step("R3 pulse third", 0, 1, 0, 0, 0, 0, 0);
    idle("R4 partial", 3);
    // R5: loss beats drift/pulse in in-lock
    step("R5 lost in in-lock", 0, 1, 1, 1, 1, 0, 0);
    // R6 holdover waits
    idle("R6 hold no back", 2);
    step("R6 back no verdict", 0, 0, 0, 1, 0, 0, 0);
    step("R5 lost+back in hold", 0, 0, 1, 1, 1, 0, 0);
    step("R10 pulse in hold", 1, 1, 0, 0, 1, 1, 1);
    // R6 drift ok -> in-lock, counter restarts
    step("R6 back ok to in-lock", 0, 0, 0, 1, 1, 0, 0);
    idle("R4 period after hold", PERIOD + 1);
    // R5 lost in sync output
    step("R5 lost in sync out", 0, 1, 1, 0, 0, 0, 0);
    // R6 far beats ok
    step("R6 back far to resync", 0, 0, 0, 1, 1, 1, 0);
    step("R10 pulse in resync", 0, 1, 0, 1, 1, 0, 0);
    step("R5 lost+ach in resync", 1, 0, 1, 0, 0, 0, 0);
    step("R6 far again", 0, 0, 0, 1, 0, 1, 0);
    // R7
    step("R7 resync to sync out", 1, 0, 0, 0, 0, 0, 0);
    step("R3 pulse to in-lock", 0, 1, 0, 0, 0, 0, 0);
    step("R5 lost to hold", 0, 0, 1, 0, 0, 0, 0);
    // R6 ref lost beats far
    step("R6 back ref to init", 0, 0, 0, 1, 1, 1, 1);
    idle("R2 init wait", 2);
    step("R2 init to sync out", 1, 0, 0, 0, 0, 0, 0);
    // reset in mid-run
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    mState = 0; mLockCycles = 0; mLoad = 0;
    check("R1 state", int'(state), 0);
    check("R1 cmpLoad", int'(cmpLoad), 0);
    check("R1 loopEn", int'(loopEn), 1);
    rstN = 1'b1;
    idle("R1 after second release", 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule